// File: doc/BRIEF.md
# Power-Up Battery Presence Sequencer

This block runs one decision sequence each time the input supply comes up. It tells the charger whether a battery is attached or whether the battery node is only loaded by system capacitance. A power-on-reset pulse from the supply monitor starts the sequence, but only while the supply is present.

The sequence has three phases. First, a discharge load drains any residual charge from the battery node for a fixed time. If the node is below the short-circuit threshold when the load ends, linear charging brings it back up. Once the node is above that threshold, PWM charging starts with the float target forced down to 4 V. A bare capacitor rises quickly under these conditions, while a real battery does not. If the node crosses the 3.7 V comparator inside a bounded window, the battery is declared absent. The block then goes to high-impedance mode, reports an all-ones fault code and inhibits the long safety timer. Otherwise the float target goes back to the programmed value, PWM charging continues, and a single done pulse marks the result.

All phase lengths are counted in clock cycles and set by parameters. Losing the supply at any point sends the sequencer back to idle.

Top module: `batt_probe_seq`

## Requirements
- R1: After reset, and in idle, every enable output, the done output and the safety-timer inhibit are low, and the fault code is 3'b000.
- R2: A cycle with `por_pulse` and `supply_ok` both high starts the load phase. `load_en` is then high for exactly LOAD_CYC cycles. A power-on pulse while the supply is absent, or while a sequence is already running, has no effect.
- R3: If `batt_below_short` is high at the last load cycle, `lin_chg_en` stays high until `batt_below_short` is sampled low. The probe phase starts on the following cycle.
- R4: If `batt_below_short` is low at the last load cycle, the probe phase starts at once. In the probe phase, `pwm_en` and `float_force_4v` are both high.
- R5: If `batt_above_thr` is sampled high at any of the WIN_CYC clock edges of the probe phase, the block enters the absent state. It holds that state until the supply is lost. In the absent state, `hiz_mode` is high, `fault_code` is 3'b111, `safety_tmr_inhibit` is high and every charge enable is low.
- R6: If `batt_above_thr` stays low for all WIN_CYC probe edges, `float_force_4v` drops, `pwm_en` stays high and `fault_code` stays 3'b000.
- R7: `done` is high for exactly the first cycle of the charge state reached through R6. It never rises on the absent path.
- R8: If `supply_ok` is sampled low in any state, the next cycle is idle with all outputs as in R1, including the timer inhibit. A new power-on pulse is needed to restart.
- R9: At most one of `load_en`, `lin_chg_en`, `pwm_en`, `hiz_mode` is high in any cycle, and `float_force_4v` is high only together with `pwm_en`.
- R10: `batt_above_thr` has no effect outside the probe phase, and `batt_below_short` has no effect during the probe and charge phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_pulse | input | 1 | Supply power-on-reset event |
| supply_ok | input | 1 | Input supply present |
| batt_below_short | input | 1 | Battery node below short-circuit threshold |
| batt_above_thr | input | 1 | Battery node above 3.7 V |
| load_en | output | 1 | Discharge load on battery node |
| lin_chg_en | output | 1 | Linear precharge source enable |
| pwm_en | output | 1 | Switching charger enable |
| float_force_4v | output | 1 | Force float target to 4 V instead of the register value |
| hiz_mode | output | 1 | High-impedance mode request |
| fault_code | output | 3 | Fault code, 3'b111 when battery absent |
| safety_tmr_inhibit | output | 1 | Holds off the long safety timer |
| done | output | 1 | One-cycle pulse: battery present |

## Verification
The bench sweeps the edge where the 3.7 V flag rises across every position of the probe window, plus one position just past it. An off-by-one window would either miss the last edge and report a present battery, or catch a rise in the charge state and wrongly go high-impedance. It drops the supply in each phase and checks that the inhibit and fault code clear and that no restart happens without a new power-on pulse. It also fires extra power-on pulses in the middle of a sequence: a design that accepted them would restart the load and stretch it beyond LOAD_CYC cycles.

// File: rtl/batt_probe_pkg.sv
`timescale 1ns/1ps
package batt_probe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_LINEAR = 3'd2,
    ST_PROBE  = 3'd3,
    ST_CHARGE = 3'd4,
    ST_ABSENT = 3'd5
  } seq_state_t;

  localparam logic [2:0] FAULT_NONE    = 3'b000;
  localparam logic [2:0] FAULT_NO_BATT = 3'b111;

  // true on the final cycle of a phase that lasts len cycles
  function automatic logic phase_last(input logic [31:0] cnt, input logic [31:0] len);
    return (cnt + 32'd1) == len;
  endfunction

  // counter width able to hold values up to the larger limit
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/probe_timer.sv
`timescale 1ns/1ps
module probe_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/probe_fsm.sv
`timescale 1ns/1ps
module probe_fsm
  import batt_probe_pkg::*;
#(
  parameter int unsigned LOAD_CYC = 16,
  parameter int unsigned WIN_CYC  = 8,
  parameter int unsigned CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_pulse,
  input  logic          supply_ok,
  input  logic          batt_below_short,
  input  logic          batt_above_thr,
  input  logic [CW-1:0] cnt,
  output seq_state_t    state,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          ev_load_end,
  output logic          ev_win_end,
  output logic          ev_absent,
  output logic          done
);
  seq_state_t nxt;

  assign ev_load_end = (state == ST_LOAD) && phase_last(32'(cnt), 32'(LOAD_CYC));
  assign ev_absent   = (state == ST_PROBE) && batt_above_thr;
  assign ev_win_end  = (state == ST_PROBE) && !batt_above_thr
                       && phase_last(32'(cnt), 32'(WIN_CYC));
  assign cnt_en      = (state == ST_LOAD) || (state == ST_PROBE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (por_pulse && supply_ok) nxt = ST_LOAD;
      ST_LOAD:   if (ev_load_end) nxt = batt_below_short ? ST_LINEAR : ST_PROBE;
      ST_LINEAR: if (!batt_below_short) nxt = ST_PROBE;
      ST_PROBE:  if (ev_absent) nxt = ST_ABSENT;
                 else if (ev_win_end) nxt = ST_CHARGE;
      default:   nxt = state;
    endcase
    if (!supply_ok) nxt = ST_IDLE;
  end

  assign cnt_clr = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_PROBE) && (nxt == ST_CHARGE);
    end
  end
endmodule

// File: rtl/probe_outdec.sv
`timescale 1ns/1ps
module probe_outdec
  import batt_probe_pkg::*;
(
  input  seq_state_t state,
  output logic       load_en,
  output logic       lin_chg_en,
  output logic       pwm_en,
  output logic       float_force_4v,
  output logic       hiz_mode,
  output logic [2:0] fault_code,
  output logic       safety_tmr_inhibit
);
  always_comb begin
    load_en            = (state == ST_LOAD);
    lin_chg_en         = (state == ST_LINEAR);
    pwm_en             = (state == ST_PROBE) || (state == ST_CHARGE);
    float_force_4v     = (state == ST_PROBE);
    hiz_mode           = (state == ST_ABSENT);
    safety_tmr_inhibit = (state == ST_ABSENT);
    fault_code         = (state == ST_ABSENT) ? FAULT_NO_BATT : FAULT_NONE;
  end
endmodule

// File: rtl/batt_probe_seq.sv
`timescale 1ns/1ps
module batt_probe_seq
  import batt_probe_pkg::*;
#(
  parameter int unsigned LOAD_CYC = 16,
  parameter int unsigned WIN_CYC  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_pulse,
  input  logic       supply_ok,
  input  logic       batt_below_short,
  input  logic       batt_above_thr,
  output logic       load_en,
  output logic       lin_chg_en,
  output logic       pwm_en,
  output logic       float_force_4v,
  output logic       hiz_mode,
  output logic [2:0] fault_code,
  output logic       safety_tmr_inhibit,
  output logic       done
);
  localparam int unsigned CW = cnt_bits(LOAD_CYC, WIN_CYC);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;
  logic          ev_load_end, ev_win_end, ev_absent;

  probe_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  probe_fsm #(.LOAD_CYC(LOAD_CYC), .WIN_CYC(WIN_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .supply_ok(supply_ok),
    .batt_below_short(batt_below_short), .batt_above_thr(batt_above_thr),
    .cnt(cnt), .state(state), .cnt_clr(cnt_clr), .cnt_en(cnt_en),
    .ev_load_end(ev_load_end), .ev_win_end(ev_win_end), .ev_absent(ev_absent),
    .done(done)
  );

  probe_outdec u_dec (
    .state(state), .load_en(load_en), .lin_chg_en(lin_chg_en), .pwm_en(pwm_en),
    .float_force_4v(float_force_4v), .hiz_mode(hiz_mode),
    .fault_code(fault_code), .safety_tmr_inhibit(safety_tmr_inhibit)
  );
endmodule

// File: rtl/batt_probe_chk.sv
`timescale 1ns/1ps
module batt_probe_chk #(
  parameter int unsigned LOAD_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       load_en,
  input logic       lin_chg_en,
  input logic       pwm_en,
  input logic       float_force_4v,
  input logic       hiz_mode,
  input logic [2:0] fault_code,
  input logic       safety_tmr_inhibit,
  input logic       done,
  input logic       ev_load_end,
  input logic       ev_win_end,
  input logic       ev_absent
);
  logic [31:0] load_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_run <= '0;
    else if (load_en) load_run <= load_run + 32'd1;
    else              load_run <= '0;
  end

  // R2: load phase never outlasts its window and ends exactly on it unless the supply dropped
  assert_load_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_run <= 32'(LOAD_CYC));
  assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load_en) && $past(supply_ok)) |-> (load_run == 32'(LOAD_CYC)));
  // R5: absent state carries its fault code and inhibit, and stays while supplied
  assert_absent_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_mode |-> (fault_code == 3'b111) && safety_tmr_inhibit);
  assert_absent_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_mode && supply_ok) |=> hiz_mode);
  assert_absent_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_absent && supply_ok) |=> hiz_mode);
  // R7: done follows a completed window and comes once
  assert_done_after_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_win_end && supply_ok) |=> done && pwm_en && !float_force_4v);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: supply loss clears everything on the next cycle
  assert_supply_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !(load_en || lin_chg_en || pwm_en || hiz_mode || safety_tmr_inhibit)
                   && (fault_code == 3'b000));
  // R9: exclusive drive enables, force only with PWM
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, lin_chg_en, pwm_en, hiz_mode}));
  assert_force_pwm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    float_force_4v |-> pwm_en);
  // R3/R4: load end hands over to linear or probe
  assert_load_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load_end && supply_ok) |=> (lin_chg_en || float_force_4v));
endmodule

bind batt_probe_seq batt_probe_chk #(.LOAD_CYC(LOAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .load_en(load_en),
  .lin_chg_en(lin_chg_en), .pwm_en(pwm_en), .float_force_4v(float_force_4v),
  .hiz_mode(hiz_mode), .fault_code(fault_code),
  .safety_tmr_inhibit(safety_tmr_inhibit), .done(done),
  .ev_load_end(ev_load_end), .ev_win_end(ev_win_end), .ev_absent(ev_absent)
);

// File: tb/batt_probe_seq_test.sv
`timescale 1ns/1ps
module batt_probe_seq_test;
  localparam int LC = 8;
  localparam int WC = 6;

  // expected-vector phase codes
  localparam int P_IDLE = 0, P_LOAD = 1, P_LIN = 2, P_PROBE = 3, P_CHG = 4, P_ABS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 1'b0, supply_ok = 1'b0, batt_below_short = 1'b0, batt_above_thr = 1'b0;
  logic load_en, lin_chg_en, pwm_en, float_force_4v, hiz_mode, safety_tmr_inhibit, done;
  logic [2:0] fault_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  batt_probe_seq #(.LOAD_CYC(LC), .WIN_CYC(WC)) uut (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .supply_ok(supply_ok),
    .batt_below_short(batt_below_short), .batt_above_thr(batt_above_thr),
    .load_en(load_en), .lin_chg_en(lin_chg_en), .pwm_en(pwm_en),
    .float_force_4v(float_force_4v), .hiz_mode(hiz_mode), .fault_code(fault_code),
    .safety_tmr_inhibit(safety_tmr_inhibit), .done(done)
  );

  // {load, lin, pwm, force, hiz, inhibit, done, fault[2:0]}
  function automatic logic [9:0] expect_vec(input int ph, input bit dn);
    case (ph)
      P_LOAD:  return 10'b1000000_000;
      P_LIN:   return 10'b0100000_000;
      P_PROBE: return 10'b0011000_000;
      P_CHG:   return {6'b001000, dn, 3'b000};
      P_ABS:   return 10'b0000110_111;
      default: return 10'b0;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int ph, input bit dn);
    logic [9:0] act, exp;
    act = {load_en, lin_chg_en, pwm_en, float_force_4v, hiz_mode,
           safety_tmr_inhibit, done, fault_code};
    exp = expect_vec(ph, dn);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // start a sequence and walk through load and optional linear phase to the probe entry
  task automatic to_probe(input int lin_cyc);
    supply_ok = 1'b1; por_pulse = 1'b1;
    tick();
    por_pulse = 1'b0;
    check("R2 load start", P_LOAD, 1'b0);
    for (int k = 1; k < LC; k++) begin
      if (k == 2) por_pulse = 1'b1;  // R2: pulse mid-sequence ignored
      tick();
      por_pulse = 1'b0;
      check("R2 load hold", P_LOAD, 1'b0);
    end
    batt_below_short = (lin_cyc > 0);
    tick();
    if (lin_cyc > 0) begin
      check("R3 linear entry", P_LIN, 1'b0);
      for (int k = 1; k < lin_cyc; k++) begin
        batt_above_thr = 1'b1;  // R10: ignored here
        tick();
        batt_above_thr = 1'b0;
        check("R3 linear hold", P_LIN, 1'b0);
      end
      batt_below_short = 1'b0;
      tick();
      check("R3 probe after linear", P_PROBE, 1'b0);
    end else begin
      check("R4 probe direct", P_PROBE, 1'b0);
    end
  endtask

  task automatic drop_supply(input string req);
    supply_ok = 1'b0;
    batt_below_short = 1'b0; batt_above_thr = 1'b0;
    tick();
    check(req, P_IDLE, 1'b0);
    supply_ok = 1'b1;
    tick();
    check("R8 no restart without pulse", P_IDLE, 1'b0);
  endtask

  initial begin
    repeat (3) tick();
    check("R1 reset", P_IDLE, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 idle", P_IDLE, 1'b0);

    // R2: pulse without supply ignored
    por_pulse = 1'b1; supply_ok = 1'b0;
    tick();
    por_pulse = 1'b0;
    check("R2 pulse without supply", P_IDLE, 1'b0);

    // R5: rise at every edge position of the probe window
    for (int j = 1; j <= WC; j++) begin
      to_probe(j % 3);
      for (int k = 1; k < j; k++) begin
        tick();
        check("R4 probe hold", P_PROBE, 1'b0);
      end
      batt_above_thr = 1'b1;
      tick();
      batt_above_thr = 1'b0;
      check("R5 absent entry", P_ABS, 1'b0);
      por_pulse = 1'b1;
      repeat (3) tick();
      por_pulse = 1'b0;
      check("R5 absent latched", P_ABS, 1'b0);
      drop_supply("R8 loss from absent");
    end

    // R6/R7: battery present, with short flag toggling in probe (R10)
    for (int lin = 0; lin < 3; lin++) begin
      to_probe(lin);
      for (int k = 1; k < WC; k++) begin
        batt_below_short = k[0];
        tick();
        check("R10 probe ignores short flag", P_PROBE, 1'b0);
      end
      batt_below_short = 1'b0;
      tick();
      check("R6 R7 charge with done", P_CHG, 1'b1);
      batt_above_thr = 1'b1;  // one edge past the window
      tick();
      check("R7 done single / R10 above ignored", P_CHG, 1'b0);
      batt_below_short = 1'b1;
      repeat (2) tick();
      check("R10 charge holds", P_CHG, 1'b0);
      drop_supply("R8 loss from charge");
    end

    // R8: supply loss in load, linear and probe phases
    supply_ok = 1'b1; por_pulse = 1'b1;
    tick();
    por_pulse = 1'b0;
    repeat (3) tick();
    drop_supply("R8 loss from load");
    to_probe(4);
    drop_supply("R8 loss from probe");
    supply_ok = 1'b1; por_pulse = 1'b1;
    tick();
    por_pulse = 1'b0;
    batt_below_short = 1'b1;
    repeat (LC + 1) tick();
    check("R3 linear waits", P_LIN, 1'b0);
    drop_supply("R8 loss from linear");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: expected end of run, got timeout");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule